// File: doc/BRIEF.md
# Rotor Cipher Sequencing Controller

This block sequences a character-serial rotor cipher datapath that works on 5-bit letter codes (0 to 25). A pulse on `new_char_i` starts one full encode pass. The pass loads the incoming letter and runs it through the plugboard swap. It then crosses every rotor on the way in, takes one reflector lookup, and crosses the rotors again in reverse order. A second plugboard swap follows, and the result is loaded into the output register. Single letters and an unbroken stream are handled in the same way. The wheel tables, the reflector table, the plugboard memory and the modulo-26 adders all sit outside this block. The block only drives their selects, strobes and enables.

Two state machines do the work. An operation machine walks through the stages of the pass. A wheel sequencer nested under it spends a fixed number of sub-steps on each rotor and walks the rotor index upward on the way in and downward on the way out. The length of a pass therefore follows the configured wheel count. While the set phase is active, the rotor position logic is enabled on every clock so that start positions and plugboard pairs can be written. During encoding, the rotors advance once per letter.

Top module: `rotor_ctrl`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it is released, all outputs are 0 and `stage_o` reads idle (0). Asserting reset in the middle of a pass clears the outputs at once.
- R2: A `new_char_i` pulse seen while idle with `set_mode_i` low starts a pass that lasts 4*N+5 cycles for N wheels (17 for N=3). `busy_o` is high from the load cycle through the output cycle inclusive, and the block is idle in the cycle after.
- R3: `stage_o` follows this order: load (1), input plugboard (2), forward wheels (3) for 2N cycles, reflector (4) for one cycle, reverse wheels (5) for 2N cycles, output plugboard (6), output (7). Idle reads 0.
- R4: In forward wheel cycles, `wheel_idx_o` counts 0 up to N-1 and holds each value for two cycles, with `wheel_sub_o` showing 0 (offset add) and then 1 (table lookup). Reverse wheel cycles count the index from N-1 down to 0 with the same sub-step pattern.
- R5: `rev_ofs_o` selects the add-13 offset. It is high exactly in the reverse-wheel cycles where `wheel_sub_o` is 0, and low everywhere else.
- R6: `plug_rd_o` is high in both plugboard cycles when `use_plug_i` is 1. It stays low throughout a pass when `use_plug_i` is 0, which leaves the letter unchanged.
- R7: A `new_char_i` held high while `busy_o` is high has no effect. The pass keeps its length and `rotor_step_o` does not pulse again.
- R8: While idle with `set_mode_i` high, `pos_load_o`, `plug_we_o` and `rot_en_o` are high on every clock. No pass starts in this state, even if `new_char_i` is high.
- R9: `rotor_step_o` pulses exactly once per pass, in the load cycle, together with `in_sel_o`. `rot_en_o` is high only in that cycle or in the set phase.
- R10: `done_o` and `out_load_o` are high together for exactly one cycle, the output cycle.
- R11: A `num_wheels_i` value of 0 acts as 1. The wheel count is sampled when a pass starts, so changing `num_wheels_i` during a pass has no effect on that pass.
- R12: If `new_char_i` stays high, the next pass starts with a single idle cycle between the output cycle and the next load cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| set_mode_i | input | 1 | Set phase: load rotor positions and plugboard pairs |
| new_char_i | input | 1 | Start an encode pass |
| use_plug_i | input | 1 | Apply the plugboard swap (0 = pass-through) |
| num_wheels_i | input | 3 | Configured wheel count, 1 to 7 (0 acts as 1) |
| busy_o | output | 1 | Pass in progress |
| done_o | output | 1 | Output cycle marker |
| stage_o | output | 3 | Datapath stage select code |
| in_sel_o | output | 1 | Select the input letter into the working register |
| plug_rd_o | output | 1 | Plugboard memory read strobe |
| plug_we_o | output | 1 | Plugboard memory write strobe (set phase) |
| wheel_idx_o | output | 3 | Rotor table currently addressed |
| wheel_sub_o | output | 1 | Wheel sub-step: 0 offset add, 1 lookup |
| rev_ofs_o | output | 1 | Select the +13 offset for the reverse pass |
| rotor_step_o | output | 1 | Advance the rotor positions once |
| pos_load_o | output | 1 | Load rotor positions (set phase) |
| rot_en_o | output | 1 | Rotor position logic clock enable |
| out_load_o | output | 1 | Output register load enable |

## Verification
The hardest case to reach from the ports is a configuration input that changes, or a start request that repeats, while the two machines are handing control to each other in the middle of a pass. Either event must leave the pass length and the index walk unchanged. The directed passes make this happen in three ways. One holds `new_char_i` high for the whole pass and into the next one. One changes `num_wheels_i` in the load cycle. One pulls reset partway through the forward wheels. Every cycle of every pass is compared with a stage table built from the wheel count, for wheel counts of 0, 1, 2, 3 and 7.

// File: rtl/rc_pkg.sv
package rc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_LOAD     = 3'd1,
    ST_PLUG_IN  = 3'd2,
    ST_FWD      = 3'd3,
    ST_REFL     = 3'd4,
    ST_REV      = 3'd5,
    ST_PLUG_OUT = 3'd6,
    ST_OUT      = 3'd7
  } stage_e;
endpackage

// File: rtl/rc_wheel_seq.sv
module rc_wheel_seq #(
  parameter int WHEEL_W   = 3,
  parameter int WHEEL_CYC = 2,
  localparam int SUB_W    = (WHEEL_CYC > 1) ? $clog2(WHEEL_CYC) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic               dir_rev_i,
  input  logic [WHEEL_W-1:0] nw_i,
  output logic [WHEEL_W-1:0] idx_o,
  output logic [SUB_W-1:0]   sub_o,
  output logic               last_o,
  output logic               rev_ofs_o
);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(WHEEL_CYC - 1);

  logic [WHEEL_W-1:0] cnt_q;
  logic [SUB_W-1:0]   sub_q;
  logic               wheel_end;

  assign wheel_end = (sub_q == SUB_LAST);
  assign last_o    = run_i && wheel_end && (cnt_q == nw_i - WHEEL_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sub_q <= '0;
    end else if (!run_i || last_o) begin
      cnt_q <= '0;
      sub_q <= '0;
    end else if (wheel_end) begin
      cnt_q <= cnt_q + WHEEL_W'(1);
      sub_q <= '0;
    end else begin
      sub_q <= sub_q + SUB_W'(1);
    end
  end

  always_comb begin
    idx_o     = '0;
    sub_o     = '0;
    rev_ofs_o = 1'b0;
    if (run_i) begin
      idx_o     = dir_rev_i ? (nw_i - WHEEL_W'(1) - cnt_q) : cnt_q;
      sub_o     = sub_q;
      rev_ofs_o = dir_rev_i && (sub_q == '0);
    end
  end

  a_r4_idx_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (idx_o < nw_i));
  a_r5_ofs_then_lookup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rev_ofs_o |=> (run_i && sub_o == SUB_W'(1)));
endmodule

// File: rtl/rc_op_fsm.sv
module rc_op_fsm
  import rc_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  logic   wheel_last_i,
  input  logic   use_plug_i,
  output stage_e stage_o,
  output logic   busy_o,
  output logic   done_o,
  output logic   out_load_o,
  output logic   in_sel_o,
  output logic   plug_rd_o,
  output logic   step_o,
  output logic   run_o,
  output logic   dir_rev_o
);
  stage_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (start_i) state_d = ST_LOAD;
      ST_LOAD:     state_d = ST_PLUG_IN;
      ST_PLUG_IN:  state_d = ST_FWD;
      ST_FWD:      if (wheel_last_i) state_d = ST_REFL;
      ST_REFL:     state_d = ST_REV;
      ST_REV:      if (wheel_last_i) state_d = ST_PLUG_OUT;
      ST_PLUG_OUT: state_d = ST_OUT;
      ST_OUT:      state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign stage_o    = state_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_OUT);
  assign out_load_o = (state_q == ST_OUT);
  assign in_sel_o   = (state_q == ST_LOAD);
  assign step_o     = (state_q == ST_LOAD);
  assign plug_rd_o  = use_plug_i && (state_q == ST_PLUG_IN || state_q == ST_PLUG_OUT);
  assign run_o      = (state_q == ST_FWD) || (state_q == ST_REV);
  assign dir_rev_o  = (state_q == ST_REV);

  a_r3_refl_after_fwd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_REFL) |-> ($past(state_q) == ST_FWD));
  a_r7_no_restart_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> (state_q != ST_LOAD));
  a_r10_done_then_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!busy_o && !done_o));
endmodule

// File: rtl/rc_step_gate.sv
module rc_step_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_mode_i,
  input  logic idle_i,
  input  logic step_i,
  output logic pos_load_o,
  output logic plug_we_o,
  output logic rot_en_o
);
  // set phase: every clock; encode phase: once per letter
  assign pos_load_o = set_mode_i && idle_i;
  assign plug_we_o  = set_mode_i && idle_i;
  assign rot_en_o   = pos_load_o || step_i;

  a_r8_load_only_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_load_o |-> (idle_i && !step_i));
  a_r9_step_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> !step_i);
endmodule

// File: rtl/rotor_ctrl.sv
module rotor_ctrl
  import rc_pkg::*;
#(
  parameter int WHEEL_W   = 3,
  parameter int WHEEL_CYC = 2,
  localparam int SUB_W    = (WHEEL_CYC > 1) ? $clog2(WHEEL_CYC) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               set_mode_i,
  input  logic               new_char_i,
  input  logic               use_plug_i,
  input  logic [WHEEL_W-1:0] num_wheels_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [2:0]         stage_o,
  output logic               in_sel_o,
  output logic               plug_rd_o,
  output logic               plug_we_o,
  output logic [WHEEL_W-1:0] wheel_idx_o,
  output logic [SUB_W-1:0]   wheel_sub_o,
  output logic               rev_ofs_o,
  output logic               rotor_step_o,
  output logic               pos_load_o,
  output logic               rot_en_o,
  output logic               out_load_o
);
  stage_e             stage;
  logic               start, run, dir_rev, wheel_last, step;
  logic [WHEEL_W-1:0] nw_q, nw_eff;

  assign start  = new_char_i && !set_mode_i;
  assign nw_eff = (num_wheels_i == '0) ? WHEEL_W'(1) : num_wheels_i;

  // wheel count frozen for the whole pass
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      nw_q <= WHEEL_W'(1);
    else if (start && !busy_o)        nw_q <= nw_eff;
  end

  rc_op_fsm u_op (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .wheel_last_i (wheel_last),
    .use_plug_i   (use_plug_i),
    .stage_o      (stage),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .out_load_o   (out_load_o),
    .in_sel_o     (in_sel_o),
    .plug_rd_o    (plug_rd_o),
    .step_o       (step),
    .run_o        (run),
    .dir_rev_o    (dir_rev)
  );

  rc_wheel_seq #(.WHEEL_W(WHEEL_W), .WHEEL_CYC(WHEEL_CYC)) u_wheel (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .dir_rev_i (dir_rev),
    .nw_i      (nw_q),
    .idx_o     (wheel_idx_o),
    .sub_o     (wheel_sub_o),
    .last_o    (wheel_last),
    .rev_ofs_o (rev_ofs_o)
  );

  rc_step_gate u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_mode_i (set_mode_i),
    .idle_i     (!busy_o),
    .step_i     (step),
    .pos_load_o (pos_load_o),
    .plug_we_o  (plug_we_o),
    .rot_en_o   (rot_en_o)
  );

  assign stage_o      = stage;
  assign rotor_step_o = step;

  a_r11_count_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(nw_q));
  a_r10_done_with_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (out_load_o && !rotor_step_o && !rev_ofs_o));
endmodule

// File: tb/tb_rotor_ctrl.sv
module tb_rotor_ctrl;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       set_mode_i = 1'b0, new_char_i = 1'b0, use_plug_i = 1'b0;
  logic [2:0] num_wheels_i = 3'd3;
  logic       busy_o, done_o, in_sel_o, plug_rd_o, plug_we_o, rev_ofs_o;
  logic       rotor_step_o, pos_load_o, rot_en_o, out_load_o;
  logic [2:0] stage_o, wheel_idx_o;
  logic [0:0] wheel_sub_o;
  int tests = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  rotor_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .set_mode_i(set_mode_i), .new_char_i(new_char_i),
    .use_plug_i(use_plug_i), .num_wheels_i(num_wheels_i), .busy_o(busy_o),
    .done_o(done_o), .stage_o(stage_o), .in_sel_o(in_sel_o), .plug_rd_o(plug_rd_o),
    .plug_we_o(plug_we_o), .wheel_idx_o(wheel_idx_o), .wheel_sub_o(wheel_sub_o),
    .rev_ofs_o(rev_ofs_o), .rotor_step_o(rotor_step_o), .pos_load_o(pos_load_o),
    .rot_en_o(rot_en_o), .out_load_o(out_load_o));

  // {stage,busy,done,out_load,in_sel,plug_rd,idx,sub,rev_ofs,step,pos_load,rot_en,plug_we}
  function automatic logic [16:0] obs();
    return {stage_o, busy_o, done_o, out_load_o, in_sel_o, plug_rd_o, wheel_idx_o,
            wheel_sub_o, rev_ofs_o, rotor_step_o, pos_load_o, rot_en_o, plug_we_o};
  endfunction

  function automatic logic [16:0] idle_vec(input bit set);
    return {3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, set, set, set};
  endfunction

  function automatic logic [16:0] pass_vec(input int i, input int n, input bit plug);
    logic [2:0] st; logic [2:0] idx; logic sub, ofs;
    int last = 4 * n + 4;
    idx = '0; sub = 1'b0; ofs = 1'b0;
    if (i == 0)                 st = 3'd1;
    else if (i == 1)            st = 3'd2;
    else if (i <= 2 * n + 1)    begin st = 3'd3; idx = 3'((i - 2) / 2); sub = 1'((i - 2) % 2); end
    else if (i == 2 * n + 2)    st = 3'd4;
    else if (i <= 4 * n + 2)    begin
      st = 3'd5; idx = 3'(n - 1 - (i - 2 * n - 3) / 2);
      sub = 1'((i - 2 * n - 3) % 2); ofs = !sub;
    end
    else if (i == 4 * n + 3)    st = 3'd6;
    else                        st = 3'd7;
    return {st, 1'b1, 1'(i == last), 1'(i == last), 1'(i == 0),
            1'(plug && (st == 3'd2 || st == 3'd6)), idx, sub, ofs,
            1'(i == 0), 1'b0, 1'(i == 0), 1'b0};
  endfunction

  task automatic check_vec(input logic [16:0] exp, input string tag);
    logic [16:0] act = obs();
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 1'b0; new_char_i = 1'b0; set_mode_i = 1'b0;
    #1 check_vec(idle_vec(0), "R1 during reset");
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check_vec(idle_vec(0), "R1 after reset");
  endtask

  task automatic run_pass(input int n_cfg, input bit plug, input bit hold, input bit chg,
                          input string tag);
    int n = (n_cfg == 0) ? 1 : n_cfg;
    int len = 4 * n + 5;
    @(negedge clk);
    num_wheels_i = 3'(n_cfg); use_plug_i = plug; new_char_i = 1'b1;
    @(negedge clk);
    for (int i = 0; i < len; i++) begin
      if (i == 0) begin
        if (!hold) new_char_i = 1'b0;
        if (chg) num_wheels_i = 3'd5;
      end
      check_vec(pass_vec(i, n, plug), tag);
      @(negedge clk);
    end
    check_vec(idle_vec(0), "R2 idle after output cycle");
    if (hold) begin
      @(negedge clk);
      check_vec(pass_vec(0, n, plug), "R12 back-to-back restart");
      new_char_i = 1'b0;
      do_reset();
    end
  endtask

  task automatic t_set_mode();
    @(negedge clk);
    set_mode_i = 1'b1; new_char_i = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check_vec(idle_vec(1), "R8 set phase enables every clock");
    end
    set_mode_i = 1'b0; new_char_i = 1'b0;
    @(negedge clk);
    check_vec(idle_vec(0), "R8 no pass started from set phase");
  endtask

  task automatic t_mid_reset();
    @(negedge clk);
    num_wheels_i = 3'd3; new_char_i = 1'b1;
    @(negedge clk); new_char_i = 1'b0;
    repeat (4) @(negedge clk);
    rst_ni = 1'b0;
    #1 check_vec(idle_vec(0), "R1 reset mid-pass");
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
    check_vec(idle_vec(0), "R1 idle after mid-pass reset");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    run_pass(3, 1'b1, 1'b0, 1'b0, "R2/R3/R4/R5/R9/R10 three wheels");
    run_pass(1, 1'b0, 1'b0, 1'b0, "R6 plugboard bypass one wheel");
    run_pass(7, 1'b1, 1'b0, 1'b0, "R4 seven wheels");
    run_pass(0, 1'b1, 1'b0, 1'b0, "R11 zero acts as one");
    run_pass(2, 1'b0, 1'b0, 1'b1, "R11 count change mid-pass");
    run_pass(3, 1'b1, 1'b1, 1'b0, "R7 new_char held while busy");
    t_set_mode();
    t_mid_reset();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule